// File: doc/BRIEF.md
# Single-Cycle RV32I Integer Core

This block is a small RV32I integer core that completes one instruction on every rising clock edge. It supports the register-register ALU operations, the register-immediate ALU operations, and word loads and stores. It has two memory ports. The fetch port presents the program counter as an address and takes back an instruction word in the same cycle. The data port presents an address, write data and a write strobe, and takes back a read word in the same cycle. Both memories are read combinationally. Every piece of state (program counter, register file, data memory) changes only on the clock edge.

A control decoder works as a pure function of the current instruction word. It drives the datapath selects: next-PC source, immediate format, comparison signedness, ALU A and B operand sources, ALU operation, memory write, register write enable and write-back source. An opcode outside the supported subset decodes to a bubble: nothing is written and the PC still advances.

Top module: `rvsc_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0. The first instruction executed after release is the word at address 0.
- R2: On every clock edge after reset, the program counter increases by exactly 4. This holds for every instruction, including unsupported ones.
- R3: Opcode 0110011 writes rd with rs1 op rs2. The operation is selected by funct3 (bits 14:12): 000 add, or sub when bit 30 is set; 001 shift left; 010 signed less-than; 011 unsigned less-than; 100 xor; 101 logical right shift, or arithmetic when bit 30 is set; 110 or; 111 and. Shift amounts use the low 5 bits of the second operand.
- R4: Opcode 0010011 uses the same funct3 map as R3. The second operand is bits 31:20 sign-extended to 32 bits. Bit 30 selects the arithmetic right shift only for funct3 101; funct3 000 is always an add.
- R5: Opcode 0100011 with funct3 010 stores rs2 at the address rs1 + the sign-extended value of {bits 31:25, bits 11:7}. `dmem_we` is high for that one cycle, and the word index is address bits 31:2.
- R6: Opcode 0000011 with funct3 010 writes rd with `dmem_rdata`, read in the same cycle at address rs1 + the sign-extended value of bits 31:20.
- R7: Register x0 always reads as zero. Writes that name x0 as destination have no effect.
- R8: Any other opcode, and loads or stores with a funct3 other than 010, write neither a register nor data memory.
- R9: A store never writes a register, and `dmem_we` is high only while a supported store is being executed.
- R10: A register written on one clock edge, whether from the ALU or from a load, supplies the operand of the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address for loads and stores |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by memory on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, valid in the same cycle |

## Verification
The assertions assume that, once reset is released, the instruction word is a known value. They also assume that both memories answer within the same cycle, so the decoded controls and the PC step are never checked against an undefined fetch. The stimulus keeps to these assumptions. Both memory models are fully initialised before reset is released, every access is word aligned and stays inside the modelled arrays, and the program is followed by all-zero words, which decode as bubbles. Results are observed only through stores. Each computed register value is written to a distinct word, and the scoreboard matches each write by its word index and data.

// File: rtl/rvsc_pkg.sv
`timescale 1ns/1ps
package rvsc_pkg;

   typedef enum logic [6:0] {
      OPC_LOAD  = 7'b0000011,
      OPC_OPIMM = 7'b0010011,
      OPC_STORE = 7'b0100011,
      OPC_OP    = 7'b0110011
   } opcode_e;

   typedef enum logic [3:0] {
      ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
      ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR,  ALU_AND
   } alu_op_e;

   typedef enum logic       { IMM_I, IMM_S }           imm_sel_e;
   typedef enum logic       { PC_PLUS4, PC_ALU }       pc_sel_e;
   typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_PC4 } wb_sel_e;

   typedef struct packed {
      pc_sel_e  pc_sel;
      imm_sel_e imm_sel;
      logic     br_un;
      logic     a_sel;     // 1: PC drives ALU A
      logic     b_sel;     // 1: immediate drives ALU B
      alu_op_e  alu_sel;
      logic     mem_rw;    // 1: store
      logic     reg_wen;
      wb_sel_e  wb_sel;
   } ctrl_t;

   localparam logic [2:0] F3_WORD = 3'b010;

endpackage

// File: rtl/rvsc_ctrl.sv
`timescale 1ns/1ps
module rvsc_ctrl
   import rvsc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [6:0] opcode,
   input  logic [2:0] funct3,
   input  logic       alt,
   output ctrl_t      ctl
);

   function automatic alu_op_e map_f3(input logic [2:0] f3, input logic alt_op);
      case (f3)
         3'b000:  return alt_op ? ALU_SUB : ALU_ADD;
         3'b001:  return ALU_SLL;
         3'b010:  return ALU_SLT;
         3'b011:  return ALU_SLTU;
         3'b100:  return ALU_XOR;
         3'b101:  return alt_op ? ALU_SRA : ALU_SRL;
         3'b110:  return ALU_OR;
         default: return ALU_AND;
      endcase
   endfunction

   always_comb begin
      ctl.pc_sel  = PC_PLUS4;
      ctl.imm_sel = IMM_I;
      ctl.br_un   = 1'b0;
      ctl.a_sel   = 1'b0;
      ctl.b_sel   = 1'b0;
      ctl.alu_sel = ALU_ADD;
      ctl.mem_rw  = 1'b0;
      ctl.reg_wen = 1'b0;
      ctl.wb_sel  = WB_ALU;
      case (opcode)
         OPC_OP: begin
            ctl.reg_wen = 1'b1;
            ctl.alu_sel = map_f3(funct3, alt);
         end
         OPC_OPIMM: begin
            ctl.reg_wen = 1'b1;
            ctl.b_sel   = 1'b1;
            ctl.alu_sel = map_f3(funct3, alt && (funct3 == 3'b101));
         end
         OPC_LOAD: begin
            if (funct3 == F3_WORD) begin
               ctl.reg_wen = 1'b1;
               ctl.b_sel   = 1'b1;
               ctl.wb_sel  = WB_MEM;
            end
         end
         OPC_STORE: begin
            if (funct3 == F3_WORD) begin
               ctl.mem_rw  = 1'b1;
               ctl.b_sel   = 1'b1;
               ctl.imm_sel = IMM_S;
            end
         end
         default: ;
      endcase
   end

   // R9: a store never also writes back
   a_r9_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.mem_rw |-> !ctl.reg_wen);

   // R8: unknown opcodes are bubbles
   a_r8_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(opcode inside {OPC_LOAD, OPC_OPIMM, OPC_STORE, OPC_OP})
         |-> (!ctl.reg_wen && !ctl.mem_rw));

endmodule

// File: rtl/rvsc_immgen.sv
`timescale 1ns/1ps
module rvsc_immgen
   import rvsc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [11:0]     hi12,   // instruction bits 31:20
   input  logic [4:0]      lo5,    // instruction bits 11:7
   input  imm_sel_e        sel,
   output logic [XLEN-1:0] imm
);
   localparam int EXT = XLEN - 12;

   logic [11:0] raw;

   always_comb begin
      case (sel)
         IMM_S:   raw = {hi12[11:5], lo5};
         default: raw = hi12;
      endcase
      imm = {{EXT{raw[11]}}, raw};
   end
endmodule

// File: rtl/rvsc_regfile.sv
`timescale 1ns/1ps
module rvsc_regfile #(
   parameter int XLEN  = 32,
   parameter int NREGS = 32,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   ra1,
   input  logic [AW-1:0]   ra2,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2,
   input  logic            we,
   input  logic [AW-1:0]   wa,
   input  logic [XLEN-1:0] wd
);
   logic [XLEN-1:0] regs [NREGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (we && (wa != '0)) begin
         regs[wa] <= wd;
      end
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];

   // R7: the zero register stays zero on both read ports
   a_r7_x0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ((ra1 == '0) |-> (rd1 == '0)) and ((ra2 == '0) |-> (rd2 == '0)));

endmodule

// File: rtl/rvsc_alu.sv
`timescale 1ns/1ps
module rvsc_alu
   import rvsc_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter bit SHIFT_BARREL = 1'b1
) (
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  alu_op_e         op,
   output logic [XLEN-1:0] y
);
   localparam int SW = $clog2(XLEN);

   logic [SW-1:0]   shamt;
   logic [XLEN-1:0] sh_left;
   logic [XLEN-1:0] sh_right;

   assign shamt = b[SW-1:0];

   generate
      if (SHIFT_BARREL) begin : g_shared_shifter
         logic [XLEN-1:0] src;
         logic [XLEN-1:0] stg [SW+1];
         logic            fill;

         always_comb begin
            for (int i = 0; i < XLEN; i++)
               src[i] = (op == ALU_SLL) ? a[XLEN-1-i] : a[i];
         end
         assign fill   = (op == ALU_SRA) & a[XLEN-1];
         assign stg[0] = src;

         for (genvar k = 0; k < SW; k++) begin : g_stage
            localparam int D = 1 << k;
            assign stg[k+1] = shamt[k] ? {{D{fill}}, stg[k][XLEN-1:D]} : stg[k];
         end

         assign sh_right = stg[SW];
         always_comb begin
            for (int i = 0; i < XLEN; i++)
               sh_left[i] = stg[SW][XLEN-1-i];
         end
      end else begin : g_native_shifter
         assign sh_left  = a << shamt;
         assign sh_right = (op == ALU_SRA) ? XLEN'($signed(a) >>> shamt) : (a >> shamt);
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_SUB:  y = a - b;
         ALU_SLL:  y = sh_left;
         ALU_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
         ALU_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
         ALU_XOR:  y = a ^ b;
         ALU_SRL,
         ALU_SRA:  y = sh_right;
         ALU_OR:   y = a | b;
         ALU_AND:  y = a & b;
         default:  y = a + b;
      endcase
   end
endmodule

// File: rtl/rvsc_core.sv
`timescale 1ns/1ps
module rvsc_core
   import rvsc_pkg::*;
#(
   parameter int          XLEN         = 32,
   parameter int          NREGS        = 32,
   parameter logic [31:0] RESET_PC     = 32'h0,
   parameter bit          SHIFT_BARREL = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic [31:0] imem_addr,
   input  logic [31:0] imem_rdata,
   output logic [31:0] dmem_addr,
   output logic [31:0] dmem_wdata,
   output logic        dmem_we,
   input  logic [31:0] dmem_rdata
);
   localparam int AW = $clog2(NREGS);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("rvsc_core: XLEN must be 32");
      end
      if (NREGS != 32) begin : g_bad_nregs
         $error("rvsc_core: NREGS must be 32 to match 5-bit register fields");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset_pc
         $error("rvsc_core: RESET_PC must be word aligned");
      end
   endgenerate

   logic [XLEN-1:0] pc, pc_next, pc_plus4;
   logic [31:0]     inst;
   ctrl_t           ctl;
   logic [XLEN-1:0] rs1_val, rs2_val, imm, alu_a, alu_b, alu_y, wb_data;
   logic [AW-1:0]   rs1_idx, rs2_idx, rd_idx;
   logic            unused_ctl;

   assign inst    = imem_rdata;
   assign rs1_idx = inst[19:15];
   assign rs2_idx = inst[24:20];
   assign rd_idx  = inst[11:7];

   rvsc_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (inst[6:0]),
      .funct3 (inst[14:12]),
      .alt    (inst[30]),
      .ctl    (ctl)
   );

   rvsc_immgen #(.XLEN(XLEN)) u_imm (
      .hi12 (inst[31:20]),
      .lo5  (inst[11:7]),
      .sel  (ctl.imm_sel),
      .imm  (imm)
   );

   rvsc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra1   (rs1_idx),
      .ra2   (rs2_idx),
      .rd1   (rs1_val),
      .rd2   (rs2_val),
      .we    (ctl.reg_wen),
      .wa    (rd_idx),
      .wd    (wb_data)
   );

   assign alu_a = ctl.a_sel ? pc  : rs1_val;
   assign alu_b = ctl.b_sel ? imm : rs2_val;

   rvsc_alu #(.XLEN(XLEN), .SHIFT_BARREL(SHIFT_BARREL)) u_alu (
      .a  (alu_a),
      .b  (alu_b),
      .op (ctl.alu_sel),
      .y  (alu_y)
   );

   assign pc_plus4 = pc + XLEN'(4);

   always_comb begin
      case (ctl.wb_sel)
         WB_MEM:  wb_data = dmem_rdata;
         WB_PC4:  wb_data = pc_plus4;
         default: wb_data = alu_y;
      endcase
   end

   assign pc_next = (ctl.pc_sel == PC_ALU) ? alu_y : pc_plus4;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= RESET_PC;
      else        pc <= pc_next;
   end

   assign imem_addr  = pc;
   assign dmem_addr  = alu_y;
   assign dmem_wdata = rs2_val;
   assign dmem_we    = ctl.mem_rw & rst_n;

   assign unused_ctl = ctl.br_un;

   // R2: strictly sequential fetch
   a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (imem_addr == $past(imem_addr) + 32'd4));

   // R5, R9: store strobe only for a word store
   a_r5_we_only_sw: assert property (@(posedge clk) disable iff (!rst_n)
      dmem_we |-> ((imem_rdata[6:0] == OPC_STORE) && (imem_rdata[14:12] == F3_WORD)));

endmodule

// File: tb/rvsc_core_tb_top.sv
`timescale 1ns/1ps
module rvsc_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;

   always #2 clk = ~clk;   // 250 MHz

   rvsc_core dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata)
   );

   logic [31:0] imem [256];
   logic [31:0] dmem [256];

   assign imem_rdata = imem[imem_addr[9:2]];
   assign dmem_rdata = dmem[dmem_addr[9:2]];

   always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

   typedef struct {
      logic [7:0]  widx;
      logic [31:0] data;
      string       tag;
   } exp_t;

   exp_t        q[$];
   exp_t        e;
   int          n_chk = 0, n_bad = 0;
   int          pc_w = 0, sidx = 0;
   bit          running = 1'b0, done = 1'b0;
   logic [31:0] exp_pc = '0;

   localparam logic [31:0] A = 32'd5;
   localparam logic [31:0] B = 32'hFFFF_FFFD;   // -3

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                         input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd);
      return {f7, rs2, rs1, f3, rd, 7'b0110011};
   endfunction
   function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                         input logic [2:0] f3, input logic [4:0] rd);
      return {imm, rs1, f3, rd, 7'b0010011};
   endfunction
   function automatic logic [31:0] enc_lw(input logic [11:0] imm, input logic [4:0] rs1, input logic [4:0] rd);
      return {imm, rs1, 3'b010, rd, 7'b0000011};
   endfunction
   function automatic logic [31:0] enc_sw(input logic [11:0] imm, input logic [4:0] rs2, input logic [4:0] rs1);
      return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
   endfunction

   task automatic put(input logic [31:0] w);
      imem[pc_w] = w;
      pc_w++;
   endtask

   // driver: store a register to the next result slot and queue the expectation
   task automatic st(input logic [4:0] rs, input logic [31:0] v, input string tag);
      put(enc_sw(12'(sidx * 4), rs, 5'd0));
      q.push_back('{8'(sidx), v, tag});
      sidx++;
   endtask

   task automatic build;
      for (int i = 0; i < 256; i++) begin imem[i] = '0; dmem[i] = '0; end
      st(5'd0, 32'd0, "R1 first word / R7 x0");
      put(enc_i(12'd5, 5'd0, 3'b000, 5'd1));
      put(enc_i(12'hFFD, 5'd0, 3'b000, 5'd2));
      put(enc_i(12'd4, 5'd0, 3'b000, 5'd11));
      put(enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd3));  st(5'd3, A + B, "R3 add");
      put(enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd4));  st(5'd4, A - B, "R3 sub");
      put(enc_r(7'h00, 5'd11, 5'd1, 3'b001, 5'd5)); st(5'd5, A << 4, "R3 sll");
      put(enc_r(7'h00, 5'd1, 5'd2, 3'b010, 5'd6));  st(5'd6, 32'd1, "R3 slt");
      put(enc_r(7'h00, 5'd1, 5'd2, 3'b011, 5'd7));  st(5'd7, 32'd0, "R3 sltu");
      put(enc_r(7'h00, 5'd2, 5'd1, 3'b100, 5'd8));  st(5'd8, A ^ B, "R3 xor");
      put(enc_r(7'h00, 5'd11, 5'd2, 3'b101, 5'd12)); st(5'd12, B >> 4, "R3 srl");
      put(enc_r(7'h20, 5'd11, 5'd2, 3'b101, 5'd13)); st(5'd13, 32'hFFFF_FFFF, "R3 sra");
      put(enc_r(7'h00, 5'd2, 5'd1, 3'b110, 5'd14)); st(5'd14, A | B, "R3 or");
      put(enc_r(7'h00, 5'd2, 5'd1, 3'b111, 5'd15)); st(5'd15, A & B, "R3 and");
      put(enc_i(12'hFF8, 5'd1, 3'b000, 5'd16));     st(5'd16, 32'hFFFF_FFFD, "R4 addi neg");
      put(enc_i(12'hFFF, 5'd1, 3'b100, 5'd17));     st(5'd17, ~A, "R4 xori");
      put(enc_i(12'h100, 5'd1, 3'b110, 5'd18));     st(5'd18, 32'h105, "R4 ori");
      put(enc_i(12'h0F0, 5'd2, 3'b111, 5'd19));     st(5'd19, B & 32'hF0, "R4 andi");
      put(enc_i(12'hFFE, 5'd2, 3'b010, 5'd20));     st(5'd20, 32'd1, "R4 slti");
      put(enc_i(12'hFFF, 5'd1, 3'b011, 5'd21));     st(5'd21, 32'd1, "R4 sltiu");
      put(enc_i(12'h003, 5'd1, 3'b001, 5'd22));     st(5'd22, 32'd40, "R4 slli");
      put(enc_i(12'h01C, 5'd2, 3'b101, 5'd23));     st(5'd23, 32'hF, "R4 srli");
      put(enc_i(12'h401, 5'd2, 3'b101, 5'd24));     st(5'd24, 32'hFFFF_FFFE, "R4 srai");
      put(enc_i(12'h400, 5'd1, 3'b000, 5'd26));     st(5'd26, A + 32'h400, "R4 addi bit30");
      put(enc_i(12'd7, 5'd0, 3'b000, 5'd0));        st(5'd0, 32'd0, "R7 addi to x0");
      put(enc_r(7'h00, 5'd1, 5'd1, 3'b000, 5'd0));  st(5'd0, 32'd0, "R7 add to x0");
      // loads and stores with a base register and negative offset
      put(enc_i(12'd200, 5'd0, 3'b000, 5'd9));
      put(enc_sw(12'hFF8, 5'd1, 5'd9)); q.push_back('{8'd48, A, "R5 sw neg offset"});
      put(enc_sw(12'd4, 5'd4, 5'd9));   q.push_back('{8'd51, A - B, "R5 sw pos offset"});
      put(enc_lw(12'hFF8, 5'd9, 5'd10)); st(5'd10, A, "R6 lw neg offset");
      put(enc_lw(12'd4, 5'd9, 5'd25));   st(5'd25, A - B, "R6 lw pos offset");
      put(enc_r(7'h00, 5'd10, 5'd10, 3'b000, 5'd27)); st(5'd27, 2 * A, "R10 use after load");
      put(enc_i(12'd1, 5'd0, 3'b000, 5'd28));
      put(enc_r(7'h00, 5'd28, 5'd28, 3'b000, 5'd28));
      put(enc_r(7'h00, 5'd28, 5'd28, 3'b000, 5'd28));
      put(enc_r(7'h00, 5'd28, 5'd28, 3'b000, 5'd28)); st(5'd28, 32'd8, "R10 chain");
      // unsupported encodings must be bubbles
      put(enc_i(12'd9, 5'd0, 3'b000, 5'd31));
      put(32'hFFFF_FFFF);
      put({12'd0, 5'd0, 3'b000, 5'd31, 7'b0000011});
      put({7'd0, 5'd1, 5'd0, 3'b000, 5'd0, 7'b0100011});
      st(5'd31, 32'd9, "R8 bubbles");
   endtask

   // monitor: PC sequence and store scoreboard
   always @(negedge clk) begin
      if (running) begin
         chk(imem_addr == exp_pc, "R2 pc step", imem_addr, exp_pc);
         exp_pc = exp_pc + 32'd4;
         if (dmem_we) begin
            if (q.size() == 0) begin
               chk(1'b0, "R8/R9 unexpected store", dmem_addr, 32'd0);
            end else begin
               e = q.pop_front();
               chk(dmem_addr[9:2] == e.widx, e.tag, {24'd0, dmem_addr[9:2]}, {24'd0, e.widx});
               chk(dmem_wdata == e.data, e.tag, dmem_wdata, e.data);
               chk(dmem_addr[1:0] == 2'b00, {e.tag, " align"}, {30'd0, dmem_addr[1:0]}, 32'd0);
            end
         end
      end
   end

   task automatic summary;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      rst_n = 1'b0;
      build();
      repeat (3) begin
         @(negedge clk);
         chk(imem_addr == 32'd0, "R1 pc in reset", imem_addr, 32'd0);
         chk(dmem_we == 1'b0, "R1 no store in reset", {31'd0, dmem_we}, 32'd0);
      end
      @(posedge clk);
      #1;
      rst_n   = 1'b1;
      running = 1'b1;
      repeat (pc_w + 8) @(negedge clk);
      #1;
      running = 1'b0;
      chk(q.size() == 0, "R5 all stores seen", q.size(), 32'd0);
      summary();
   end

   initial begin
      #20000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule